// File: doc/BRIEF.md
# Late-Write Pipelined Memory Front End

This block is a synchronous single-port memory with a deferred ("late") write protocol. On each rising clock edge it captures an address, an active-low select, an active-low global write enable and active-low per-byte write enables. A read returns its word from an output register one cycle later. A write supplies its data one cycle after its address. That address, data and byte mask are held in a write buffer. The buffer is written into the array only when the next write is accepted, however many reads come between.

Reads whose address matches the buffered write are merged byte by byte. Bytes the buffered write enabled come from the buffer, and the remaining bytes come from the array. The output driver enable falls on deselect, on writes and in the cycle that carries write data. It also falls at once when the asynchronous output enable is high, or while the asynchronous sleep input is high. During sleep all synchronous inputs are ignored and the array keeps its contents.

Top module: `lw_sram`

## Requirements
- R1: After reset the output driver enable `q_oe_o` is 0, the read register `q_o` is 0, and no address is treated as buffered.
- R2: A read (select low, write enable high) accepted on edge N drives its word on `q_o` with `q_oe_o` high after edge N+1 is not needed: the word is valid right after edge N, held until the next accepted read.
- R3: Write data on `d_i` is taken on the edge after the one that accepted the write address. After a write-accepting edge and after the data-taking edge, `q_oe_o` is 0 unless that edge also accepts a read.
- R4: A buffered write reaches the array only when the next write address is accepted. Reads in between do not commit it.
- R5: A read whose address equals the buffered address returns, for each byte, the buffer byte if that byte was enabled in the buffered write and the array byte otherwise. This includes the data arriving on the same edge as the read.
- R6: The 36-bit word is four 9-bit bytes. Byte b occupies bits [9b+8:9b] and is enabled by `be_n_i[b]` = 0. A write with `be_n_i` = 4'b1111 changes no byte.
- R7: Consecutive reads of the same address, with no write data landing, keep `q_o` constant with no intermediate change.
- R8: An edge with select high (deselect) leaves `q_oe_o` at 0 after it.
- R9: `oe_n_i` high forces `q_oe_o` to 0 immediately, independent of the clock. Returning it low restores the driver of a pending read.
- R10: While `sleep_i` is high, `q_oe_o` is 0 at once, and every synchronous input is ignored. Array contents are kept, so writes issued during sleep have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_i | input | 1 | Asynchronous sleep; high ignores inputs and disables the driver |
| oe_n_i | input | 1 | Asynchronous active-low output enable |
| sel_n_i | input | 1 | Active-low select; high deselects |
| we_n_i | input | 1 | Active-low global write enable |
| be_n_i | input | 4 | Active-low byte write enables, bit b for byte b |
| addr_i | input | 8 | Word address |
| d_i | input | 36 | Write data, presented one cycle after its address |
| q_o | output | 36 | Read data register |
| q_oe_o | output | 1 | Data bus driver enable (low means high impedance) |

## Verification
Read data and the driver enable are due right after the edge that accepts the read. Write data belongs to the following edge, so each write is followed by an operation that carries its data. The bench drives each operation at the falling edge and takes every registered sample at the next falling edge, half a cycle after the edge that produced it. The asynchronous output-enable and sleep effects are sampled 1 ns after the input changes, with no clock edge in between. Output stability during repeated reads is watched continuously by an event monitor on `q_o`.

// File: rtl/lw_sram.sv
`timescale 1ns/1ps
module lw_sram #(
  parameter int AW = 8,
  parameter int NB = 4,
  parameter int BW = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sleep_i,
  input  logic               oe_n_i,
  input  logic               sel_n_i,
  input  logic               we_n_i,
  input  logic [NB-1:0]      be_n_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [NB*BW-1:0]   d_i,
  output logic [NB*BW-1:0]   q_o,
  output logic               q_oe_o
);
  localparam int DW    = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  logic          p_vld, p_wr;
  logic [AW-1:0] p_addr;
  logic [NB-1:0] p_en;

  logic          wb_vld;
  logic [AW-1:0] wb_addr;
  logic [NB-1:0] wb_en;
  logic [DW-1:0] wb_dat;

  logic [DW-1:0] q_reg;
  logic          q_drv;

  wire acc  = !sleep_i && !sel_n_i;
  wire rd   = acc && we_n_i;
  wire wr   = acc && !we_n_i;
  wire land = !sleep_i && p_vld && p_wr;

  wire          n_vld  = land ? 1'b1   : wb_vld;
  wire [AW-1:0] n_addr = land ? p_addr : wb_addr;
  wire [NB-1:0] n_en   = land ? p_en   : wb_en;
  wire [DW-1:0] n_dat  = land ? d_i    : wb_dat;

  wire hit = n_vld && (n_addr == addr_i);

  logic [DW-1:0] rd_word;
  for (genvar b = 0; b < NB; b++) begin : g_merge
    assign rd_word[b*BW +: BW] = (hit && n_en[b]) ? n_dat[b*BW +: BW]
                                                  : mem[addr_i][b*BW +: BW];
  end

  always_ff @(posedge clk) begin
    if (rst_n && wr && n_vld) begin
      for (int b = 0; b < NB; b++)
        if (n_en[b]) mem[n_addr][b*BW +: BW] <= n_dat[b*BW +: BW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_vld   <= 1'b0;
      p_wr    <= 1'b0;
      p_addr  <= '0;
      p_en    <= '0;
      wb_vld  <= 1'b0;
      wb_addr <= '0;
      wb_en   <= '0;
      wb_dat  <= '0;
      q_reg   <= '0;
      q_drv   <= 1'b0;
    end else begin
      q_drv <= rd;
      if (sleep_i) begin
        p_vld <= 1'b0;
      end else begin
        p_vld   <= acc;
        p_wr    <= !we_n_i;
        p_addr  <= addr_i;
        p_en    <= ~be_n_i;
        wb_vld  <= n_vld;
        wb_addr <= n_addr;
        wb_en   <= n_en;
        wb_dat  <= n_dat;
        if (rd) q_reg <= rd_word;
      end
    end
  end

  assign q_o    = q_reg;
  assign q_oe_o = q_drv && !oe_n_i && !sleep_i;

  a_r8_deselect_off: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n_i && !sleep_i) |=> !q_oe_o);

  a_r3_write_bus_in: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> !q_oe_o);

  a_r9_oe_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n_i |-> !q_oe_o);

  a_r10_sleep_off: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |-> !q_oe_o);

  a_r2_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> (q_oe_o || oe_n_i || sleep_i));

  a_r7_same_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && $past(rd) && $past(rst_n) && addr_i == $past(addr_i)
     && !$past(p_vld && p_wr)) |=> $stable(q_o));
endmodule

// File: tb/lw_sram_tb.sv
`timescale 1ns/1ps
module lw_sram_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sleep_i = 1'b0;
  logic        oe_n_i = 1'b0;
  logic        sel_n_i = 1'b1;
  logic        we_n_i = 1'b1;
  logic [3:0]  be_n_i = 4'hF;
  logic [7:0]  addr_i = '0;
  logic [35:0] d_i = '0;
  logic [35:0] q_o;
  logic        q_oe_o;

  int checks = 0;
  int fails  = 0;
  bit hold_watch = 1'b0;
  int glitches = 0;
  bit done = 1'b0;

  localparam logic [35:0] VX = 36'h123456789;
  localparam logic [35:0] VY = 36'hABCDEF012;
  localparam logic [35:0] VZ = 36'h0F0F0F0F0;
  localparam logic [35:0] VW = 36'h5A5A5A5A5;
  localparam logic [35:0] VG = 36'hFFFFFFFFF;
  localparam logic [35:0] VH = 36'h000000111;

  always #2.5 clk = ~clk;

  lw_sram u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .oe_n_i(oe_n_i),
    .sel_n_i(sel_n_i), .we_n_i(we_n_i), .be_n_i(be_n_i),
    .addr_i(addr_i), .d_i(d_i), .q_o(q_o), .q_oe_o(q_oe_o)
  );

  always @(q_o) if (hold_watch) glitches++;

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic s_n, input logic w_n, input logic [3:0] b_n,
                      input logic [7:0] a, input logic [35:0] d);
    sel_n_i = s_n; we_n_i = w_n; be_n_i = b_n; addr_i = a; d_i = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 oe", {35'd0, q_oe_o}, 36'd0);
    chk("R1 q", q_o, 36'd0);
  endtask

  task automatic t_write_then_bypass;
    step(1'b0, 1'b0, 4'h0, 8'd5, 36'd0);
    chk("R3 oe after write", {35'd0, q_oe_o}, 36'd0);
    step(1'b0, 1'b1, 4'hF, 8'd5, VX);
    chk("R5 full bypass", q_o, VX);
    chk("R2 read drives", {35'd0, q_oe_o}, 36'd1);
  endtask

  task automatic t_partial_merge;
    step(1'b0, 1'b0, 4'h0, 8'd7, 36'd0);
    step(1'b0, 1'b0, 4'b1110, 8'd7, VY);
    chk("R3 oe in data cycle", {35'd0, q_oe_o}, 36'd0);
    step(1'b0, 1'b1, 4'hF, 8'd7, VZ);
    chk("R5 byte merge", q_o, {VY[35:9], VZ[8:0]});
  endtask

  task automatic t_deferred_commit;
    step(1'b0, 1'b0, 4'h0, 8'd9, 36'd0);
    step(1'b0, 1'b1, 4'hF, 8'd9, VW);
    chk("R4 buffered read", q_o, VW);
    step(1'b0, 1'b1, 4'hF, 8'd7, 36'd0);
    chk("R4 committed on next write", q_o, {VY[35:9], VZ[8:0]});
    step(1'b0, 1'b1, 4'hF, 8'd9, 36'd0);
    chk("R4 still buffered after reads", q_o, VW);
  endtask

  task automatic t_no_byte_write;
    step(1'b0, 1'b0, 4'hF, 8'd9, 36'd0);
    step(1'b0, 1'b1, 4'hF, 8'd9, VG);
    chk("R6 no-byte write keeps word", q_o, VW);
    step(1'b0, 1'b1, 4'hF, 8'd5, 36'd0);
    chk("R6 earlier commit intact", q_o, VX);
  endtask

  task automatic t_same_addr_reads;
    glitches = 0;
    hold_watch = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b1, 4'hF, 8'd5, 36'd0);
      chk("R7 repeated read value", q_o, VX);
    end
    hold_watch = 1'b0;
    chk("R7 no output change", 36'(glitches), 36'd0);
  endtask

  task automatic t_deselect;
    step(1'b1, 1'b1, 4'hF, 8'd5, 36'd0);
    chk("R8 deselect driver off", {35'd0, q_oe_o}, 36'd0);
  endtask

  task automatic t_async_oe;
    step(1'b0, 1'b1, 4'hF, 8'd5, 36'd0);
    chk("R9 driver on before", {35'd0, q_oe_o}, 36'd1);
    oe_n_i = 1'b1; #1;
    chk("R9 oe high forces off", {35'd0, q_oe_o}, 36'd0);
    oe_n_i = 1'b0; #1;
    chk("R9 oe low restores", {35'd0, q_oe_o}, 36'd1);
  endtask

  task automatic t_sleep;
    sleep_i = 1'b1; #1;
    chk("R10 sleep forces off", {35'd0, q_oe_o}, 36'd0);
    @(negedge clk);
    step(1'b0, 1'b0, 4'h0, 8'd9, 36'd0);
    step(1'b0, 1'b1, 4'hF, 8'd9, VH);
    chk("R10 read ignored in sleep", {35'd0, q_oe_o}, 36'd0);
    sleep_i = 1'b0;
    step(1'b0, 1'b1, 4'hF, 8'd9, 36'd0);
    chk("R10 contents kept", q_o, VW);
    chk("R10 driver after wake", {35'd0, q_oe_o}, 36'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_write_then_bypass();
    t_partial_merge();
    t_deferred_commit();
    t_no_byte_write();
    t_same_addr_reads();
    t_deselect();
    t_async_oe();
    t_sleep();
    step(1'b1, 1'b1, 4'hF, 8'd0, 36'd0);
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule